// File: doc/BRIEF.md
# Deduplicating Error Message Cache

This block sits behind a source of upset error-message words that arrives on a valid/error stream. It takes in each word and compares it against every entry already held. It stores only words it has not seen before. A static bypass input turns the comparison off so that every word is stored.

Stored entries are offered one at a time on a valid/ready output stream. A processor services each entry as an interrupt. After each accepted entry the block moves to the next unserviced one. Serviced entries stay in the cache until reset, so a repeat of an old upset is still recognised and dropped.

A fill-level output counts the stored entries. A sticky overflow flag marks a word lost to a full cache. A sticky critical flag marks lost content or an input overrun, and a clear input resets it.

Top module: `errcache_dedup`

## Requirements
- R1: Synchronous active-high reset empties the cache: after reset `fill_level` is 0 and `out_valid`, `out_overflow` and `crit_flag` are 0. Words stored before the reset no longer count as duplicates.
- R2: A word presented with `in_valid` high and `in_error` low is captured at the next rising edge and stored at the edge after that. `fill_level` therefore rises by one two edges after the word is presented.
- R3: With `bypass_cmp` low, a word equal to any stored entry is not stored. `fill_level` is unchanged and nothing new appears on the output stream.
- R4: With `bypass_cmp` high, every captured word is stored, even one equal to an existing entry.
- R5: A word that would be stored while `fill_level` equals `DEPTH` is dropped. `fill_level` stays at `DEPTH`, and `out_overflow` goes high and stays high until reset.
- R6: `in_error` high at a rising edge sets `crit_flag` at that edge. The word presented with it is not stored.
- R7: `in_valid` high while the previously captured word is still being compared (the cycle right after an accepted word) is an overrun. The new word is dropped and `crit_flag` is set.
- R8: `crit_clear` high at a rising edge clears `crit_flag`. If a set condition (R6, R7) occurs at the same edge, the set wins.
- R9: Entries appear on `out_word` in the order they were stored. `out_valid` is high while any stored entry is unserviced. The entry is held stable while `out_ready` is low, and one entry is consumed per edge where both are high.
- R10: Servicing an entry never lowers `fill_level`. A serviced entry still suppresses its duplicates (R3).
- R11: `DEPTH` must be one of 2, 4, 8, 16, 32 or 64, with a default of 8. `fill_level` is clog2(DEPTH)+1 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bypass_cmp | input | 1 | Static: store every word, skip the duplicate comparison |
| in_word | input | WORD_W | Incoming error-message word |
| in_valid | input | 1 | `in_word` is valid this cycle |
| in_error | input | 1 | Upstream lost content; the word is ignored |
| out_word | output | WORD_W | Oldest unserviced entry |
| out_valid | output | 1 | An unserviced entry is on `out_word` |
| out_ready | input | 1 | Consumer accepts `out_word` |
| out_overflow | output | 1 | Sticky: a word was dropped because the cache was full |
| fill_level | output | clog2(DEPTH)+1 | Number of entries held |
| crit_flag | output | 1 | Sticky critical condition |
| crit_clear | input | 1 | Clears `crit_flag` |

## Verification
The stimulus uses several input patterns, and each one separates a different behaviour:
- A run of distinct words separates storage from suppression.
- A repeat of an already serviced word, with the bypass off and then on, shows whether the comparison still covers old entries and whether the bypass defeats it.
- Two back-to-back valid words, set against the same words spaced apart, separate an overrun from normal intake.
- An error pulse with a word attached shows that the word is discarded rather than stored.
- Filling the cache to its depth and then offering one more word tells a full drop apart from a duplicate drop.
- Holding the consumer's ready low shows whether the presented entry is held steady.

// File: rtl/edc_pkg.sv
package edc_pkg;

   function automatic bit depth_ok(input int d);
      return (d == 2) || (d == 4) || (d == 8) || (d == 16) || (d == 32) || (d == 64);
   endfunction

   typedef enum logic [1:0] {
      ACT_IDLE      = 2'd0,
      ACT_STORE     = 2'd1,
      ACT_DROP_DUP  = 2'd2,
      ACT_DROP_FULL = 2'd3
   } wr_action_e;

endpackage

// File: rtl/edc_entry_store.sv
module edc_entry_store #(
   parameter int WORD_W = 35,
   parameter int DEPTH  = 8,
   parameter int CNT_W  = 4,
   parameter int IDX_W  = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_word,
   input  logic [WORD_W-1:0] probe_word,
   output logic              hit,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [WORD_W-1:0] rd_word,
   output logic [CNT_W-1:0]  count
);
   logic [WORD_W-1:0] slot_q [DEPTH];
   logic [DEPTH-1:0]  match_vec;

   always_ff @(posedge clk) begin
      if (rst) begin
         count <= '0;
      end else if (wr_en) begin
         count <= count + CNT_W'(1);
      end
   end

   genvar gi;
   generate
      for (gi = 0; gi < DEPTH; gi++) begin : g_slot
         always_ff @(posedge clk) begin
            if (wr_en && (count[IDX_W-1:0] == IDX_W'(gi))) begin
               slot_q[gi] <= wr_word;
            end
         end
         assign match_vec[gi] = (CNT_W'(gi) < count) && (slot_q[gi] == probe_word);
      end
   endgenerate

   assign hit     = |match_vec;
   assign rd_word = slot_q[rd_idx];

   a_r5_no_write_when_full: assert property (@(posedge clk) disable iff (rst)
      wr_en |-> (count < CNT_W'(DEPTH)));
   a_r10_count_never_drops: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (count >= $past(count)));
   a_r2_count_single_step: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ((count - $past(count)) <= CNT_W'(1)));

endmodule

// File: rtl/edc_service_port.sv
module edc_service_port #(
   parameter int CNT_W = 4,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CNT_W-1:0] stored,
   input  logic             take,
   output logic             pend,
   output logic [IDX_W-1:0] rd_idx
);
   logic [CNT_W-1:0] rd_ptr;

   assign pend   = (rd_ptr != stored);
   assign rd_idx = rd_ptr[IDX_W-1:0];

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_ptr <= '0;
      end else if (take && pend) begin
         rd_ptr <= rd_ptr + CNT_W'(1);
      end
   end

   a_r9_ptr_not_ahead: assert property (@(posedge clk) disable iff (rst)
      rd_ptr <= stored);
   a_r9_hold_when_stalled: assert property (@(posedge clk) disable iff (rst)
      (pend && !take) |=> (pend && $stable(rd_idx)));

endmodule

// File: rtl/edc_flag_unit.sv
module edc_flag_unit (
   input  logic clk,
   input  logic rst,
   input  logic lost_evt,
   input  logic overrun_evt,
   input  logic full_drop_evt,
   input  logic crit_clear,
   output logic crit,
   output logic ovf
);
   logic set_crit;
   assign set_crit = lost_evt || overrun_evt;

   always_ff @(posedge clk) begin
      if (rst) begin
         crit <= 1'b0;
         ovf  <= 1'b0;
      end else begin
         if (set_crit)        crit <= 1'b1;
         else if (crit_clear) crit <= 1'b0;
         if (full_drop_evt)   ovf  <= 1'b1;
      end
   end

   a_r5_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
      ovf |=> ovf);
   a_r8_clear_works: assert property (@(posedge clk) disable iff (rst)
      (crit_clear && !set_crit) |=> !crit);
   a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
      set_crit |=> crit);

endmodule

// File: rtl/errcache_dedup.sv
module errcache_dedup #(
   parameter int WORD_W = 35,
   parameter int DEPTH  = 8,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bypass_cmp,
   input  logic [WORD_W-1:0] in_word,
   input  logic              in_valid,
   input  logic              in_error,
   output logic [WORD_W-1:0] out_word,
   output logic              out_valid,
   input  logic              out_ready,
   output logic              out_overflow,
   output logic [CNT_W-1:0]  fill_level,
   output logic              crit_flag,
   input  logic              crit_clear
);
   import edc_pkg::*;

   generate
      if (!depth_ok(DEPTH)) begin : g_bad_depth
         $error("errcache_dedup: DEPTH must be 2, 4, 8, 16, 32 or 64");
      end
      if (WORD_W < 1) begin : g_bad_width
         $error("errcache_dedup: WORD_W must be at least 1");
      end
   endgenerate

   logic              stg_valid;
   logic [WORD_W-1:0] stg_word;
   logic              accept;
   logic              overrun;
   logic              hit;
   logic              is_full;
   logic [IDX_W-1:0]  rd_idx;
   wr_action_e        action;

   assign overrun = in_valid && !in_error && stg_valid;
   assign accept  = in_valid && !in_error && !stg_valid;

   always_ff @(posedge clk) begin
      if (rst) begin
         stg_valid <= 1'b0;
         stg_word  <= '0;
      end else begin
         stg_valid <= accept;
         if (accept) stg_word <= in_word;
      end
   end

   assign is_full = (fill_level == CNT_W'(DEPTH));

   always_comb begin
      action = ACT_IDLE;
      if (stg_valid) begin
         if (hit && !bypass_cmp) action = ACT_DROP_DUP;
         else if (is_full)       action = ACT_DROP_FULL;
         else                    action = ACT_STORE;
      end
   end

   edc_entry_store #(
      .WORD_W(WORD_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)
   ) u_store (
      .clk        (clk),
      .rst        (rst),
      .wr_en      (action == ACT_STORE),
      .wr_word    (stg_word),
      .probe_word (stg_word),
      .hit        (hit),
      .rd_idx     (rd_idx),
      .rd_word    (out_word),
      .count      (fill_level)
   );

   edc_service_port #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_svc (
      .clk    (clk),
      .rst    (rst),
      .stored (fill_level),
      .take   (out_ready),
      .pend   (out_valid),
      .rd_idx (rd_idx)
   );

   edc_flag_unit u_flags (
      .clk           (clk),
      .rst           (rst),
      .lost_evt      (in_error),
      .overrun_evt   (overrun),
      .full_drop_evt (action == ACT_DROP_FULL),
      .crit_clear    (crit_clear),
      .crit          (crit_flag),
      .ovf           (out_overflow)
   );

   a_r1_reset_empties: assert property (@(posedge clk)
      rst |=> (fill_level == '0 && !out_valid && !out_overflow && !crit_flag));
   a_r6_error_sets_crit: assert property (@(posedge clk) disable iff (rst)
      in_error |=> crit_flag);
   a_r7_overrun_sets_crit: assert property (@(posedge clk) disable iff (rst)
      (in_valid && stg_valid) |=> crit_flag);
   a_r3_dup_no_growth: assert property (@(posedge clk) disable iff (rst)
      (stg_valid && hit && !bypass_cmp) |=> (fill_level == $past(fill_level)));
   a_r5_full_stays_full: assert property (@(posedge clk) disable iff (rst)
      is_full |=> is_full);
   a_r5_fill_bound: assert property (@(posedge clk) disable iff (rst)
      fill_level <= CNT_W'(DEPTH));

endmodule

// File: tb/errcache_dedup_bench.sv
module errcache_dedup_bench;
   localparam int W = 35;
   localparam int D = 8;
   localparam int CW = 4;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          bypass_cmp = 1'b0;
   logic [W-1:0]  in_word = '0;
   logic          in_valid = 1'b0;
   logic          in_error = 1'b0;
   logic [W-1:0]  out_word;
   logic          out_valid;
   logic          out_ready = 1'b1;
   logic          out_overflow;
   logic [CW-1:0] fill_level;
   logic          crit_flag;
   logic          crit_clear = 1'b0;

   int n_chk = 0;
   int n_bad = 0;
   logic [W-1:0] exp_q[$];
   bit done = 1'b0;

   always #10 clk = ~clk;

   errcache_dedup #(.WORD_W(W), .DEPTH(D)) u_errcache_dedup (
      .clk(clk), .rst(rst), .bypass_cmp(bypass_cmp),
      .in_word(in_word), .in_valid(in_valid), .in_error(in_error),
      .out_word(out_word), .out_valid(out_valid), .out_ready(out_ready),
      .out_overflow(out_overflow), .fill_level(fill_level),
      .crit_flag(crit_flag), .crit_clear(crit_clear)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      #2;
   endtask

   // word presented now, captured at next edge, stored at the one after
   task automatic send(input logic [W-1:0] w, input bit expect_store);
      if (expect_store) exp_q.push_back(w);
      in_word  = w;
      in_valid = 1'b1;
      tick();
      in_valid = 1'b0;
      tick();
   endtask

   // scoreboard monitor: R9 order of delivery
   always @(negedge clk) begin
      if (!rst && out_valid && out_ready) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R9", "unexpected output word", longint'(out_word), 0);
         end else begin
            logic [W-1:0] e;
            e = exp_q.pop_front();
            chk(out_word == e, "R9", "output order", longint'(out_word), longint'(e));
         end
      end
   end

   task automatic finish_run;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      tick(); tick();
      // R1 reset state
      chk(fill_level == 0, "R1", "fill after reset", fill_level, 0);
      chk(!out_valid && !out_overflow && !crit_flag, "R1", "flags after reset",
          {out_valid, out_overflow, crit_flag}, 0);
      chk($bits(fill_level) == 4, "R11", "fill width for depth 8", $bits(fill_level), 4);
      rst = 1'b0;
      tick();

      // R2 distinct words stored, R9 order
      send(35'h1_0000_00A1, 1'b1);
      chk(fill_level == 1, "R2", "fill after first word", fill_level, 1);
      send(35'h2_0000_00B2, 1'b1);
      send(35'h3_0000_00C3, 1'b1);
      chk(fill_level == 3, "R2", "fill after three words", fill_level, 3);

      // R3 / R10 repeat of a serviced entry is dropped
      send(35'h1_0000_00A1, 1'b0);
      tick();
      chk(fill_level == 3, "R3", "duplicate dropped", fill_level, 3);
      chk(!out_valid, "R10", "serviced duplicate not offered again", out_valid, 0);

      // R9 hold while stalled
      out_ready = 1'b0;
      send(35'h4_0000_00D4, 1'b1);
      chk(out_valid && out_word == 35'h4_0000_00D4, "R9", "entry offered",
          longint'(out_word), 35'h4_0000_00D4);
      tick(); tick();
      chk(out_valid && out_word == 35'h4_0000_00D4, "R9", "entry held while stalled",
          longint'(out_word), 35'h4_0000_00D4);
      chk(fill_level == 4, "R10", "fill with pending entry", fill_level, 4);
      out_ready = 1'b1;
      tick();

      // R4 bypass stores a duplicate
      bypass_cmp = 1'b1;
      send(35'h2_0000_00B2, 1'b1);
      chk(fill_level == 5, "R4", "bypass stores duplicate", fill_level, 5);
      bypass_cmp = 1'b0;
      tick();

      // R6 error input sets critical, word ignored
      in_word = 35'h5_0000_00E5; in_valid = 1'b1; in_error = 1'b1;
      tick();
      in_valid = 1'b0; in_error = 1'b0;
      tick();
      chk(crit_flag, "R6", "critical after error", crit_flag, 1);
      chk(fill_level == 5, "R6", "errored word not stored", fill_level, 5);

      // R8 clear, then set wins over clear
      crit_clear = 1'b1;
      tick();
      crit_clear = 1'b0;
      chk(!crit_flag, "R8", "clear resets critical", crit_flag, 0);
      in_error = 1'b1; crit_clear = 1'b1;
      tick();
      in_error = 1'b0; crit_clear = 1'b0;
      chk(crit_flag, "R8", "set wins over clear", crit_flag, 1);
      crit_clear = 1'b1;
      tick();
      crit_clear = 1'b0;

      // R7 back-to-back words: second is an overrun
      exp_q.push_back(35'h6_0000_00F6);
      in_word = 35'h6_0000_00F6; in_valid = 1'b1;
      tick();
      in_word = 35'h7_0000_0017;
      tick();
      in_valid = 1'b0;
      tick();
      chk(fill_level == 6, "R7", "only first of back-to-back stored", fill_level, 6);
      chk(crit_flag, "R7", "overrun sets critical", crit_flag, 1);
      crit_clear = 1'b1;
      tick();
      crit_clear = 1'b0;

      // R5 fill to depth then overflow
      send(35'h0_1111_1111, 1'b1);
      send(35'h0_2222_2222, 1'b1);
      chk(fill_level == 8, "R5", "cache full", fill_level, 8);
      chk(!out_overflow, "R5", "no overflow at exactly full", out_overflow, 0);
      send(35'h0_3333_3333, 1'b0);
      chk(fill_level == 8, "R5", "word dropped when full", fill_level, 8);
      chk(out_overflow, "R5", "overflow raised", out_overflow, 1);
      tick(); tick(); tick();
      chk(out_overflow, "R5", "overflow sticky", out_overflow, 1);
      chk(exp_q.size() == 0, "R9", "all expected entries delivered", exp_q.size(), 0);

      // R1 reset empties, old words no longer duplicates
      rst = 1'b1;
      tick(); tick();
      rst = 1'b0;
      chk(fill_level == 0 && !out_overflow && !out_valid, "R1", "reset empties cache",
          fill_level, 0);
      send(35'h1_0000_00A1, 1'b1);
      chk(fill_level == 1, "R1", "word stored again after reset", fill_level, 1);
      tick();
      chk(exp_q.size() == 0, "R9", "final entry delivered", exp_q.size(), 0);

      done = 1'b1;
      finish_run();
   end
endmodule